// File: doc/BRIEF.md
# IDE Access Timing Configuration Encoder

This block turns the negotiated transfer modes of the two drives on one IDE channel into packed 32-bit access-timing words. It also drives the channel's timing register with those words. Each drive supplies a presence flag, a multiword-DMA enable, an Ultra-DMA enable and three mode numbers (PIO, multiword DMA, Ultra DMA). A single variant input picks the controller generation. The older one counts in 30 ns ticks and the newer one counts in 15 ns ticks. Each generation has its own bit layout, recovery offset and clamping rules.

A one-cycle `start` pulse captures all inputs. The block then computes both words. It writes the first nonzero word (drive 0 before drive 1) to the timing-register output and pulses `done`. When both words are nonzero and differ, the block enables per-select switching. After that, each `sel_valid` pulse writes the selected drive's word with a one-cycle `tim_we` strobe.

The control state machine has three states:
- `ST_IDLE` waits for work. It goes to `ST_CALC` on an accepted start (transition *accept*) and otherwise serves drive selects (transition *hold*).
- `ST_CALC` latches both computed words (transition *latch*, always to `ST_DECIDE`).
- `ST_DECIDE` issues the initial write, sets the switching flag and pulses `done` (transition *finish*, always back to `ST_IDLE`).

Top module: `ide_tim_enc`

## Requirements
- R1: After reset, `done`, `tim_we`, `switch_en`, `tim_word`, `word0` and `word1` are all zero.
- R2: A time in ns becomes a tick count by dividing and rounding up. The divisor is 30 when `variant`=0 (legacy) and 15 when `variant`=1 (newer). Mode times are:
  - PIO cycle/active: mode 0 is 600/180, 1 is 390/150, 2 is 240/105, 3 is 180/90, 4 is 120/75.
  - Multiword DMA: mode 0 is 480/240, 1 is 165/90, 2 is 120/75.
  - Ultra DMA: mode 0 is 120/180, 1 is 90/150, 2 is 60/120, 3 is 45/90, 4 is 30/90.
- R3: Legacy PIO places active ticks (clamped to at least 1) at bit 0. Recovery is cycle minus active minus 4, clamped to at least 1, and sits at bit 5.
- R4: Legacy multiword DMA places active ticks at bit 11. Recovery is cycle minus active minus 1, clamped to at least 1, and sits at bit 16. Bit 21 stays 0. In the legacy variant the Ultra-DMA enable has no effect on the word.
- R5: For the newer variant, recovery is cycle minus active with no offset and no clamp. PIO puts active at bit 0 and recovery at bit 5. Multiword DMA puts active at bit 10 and recovery at bit 15.
- R6: Newer-variant Ultra DMA sets bit 20, places cycle ticks at bit 21 and places active ticks at bit 25.
- R7: A drive with `present`=0 gets a zero word, whatever its DMA and Ultra-DMA enables say. PIO fields appear whenever the drive is present, and DMA or Ultra-DMA fields appear only when their enable is also set.
- R8: A mode number above the highest defined mode of its table (PIO 4, multiword DMA 2, Ultra DMA 4) is treated as that highest mode.
- R9: `done` pulses for one cycle exactly three clock edges after the edge that samples `start`. In that same cycle, `tim_we` is high with drive 0's word if that word is nonzero. Otherwise `tim_we` is high with drive 1's word if that word is nonzero. Otherwise `tim_we` stays low.
- R10: `switch_en` is 0 from the accepted start until `done`. From `done` on, it is 1 exactly when both words are nonzero and different.
- R11: In `ST_IDLE` with `switch_en`=1, a `sel_valid` pulse writes the word of drive `sel_drive` (0 or 1) to `tim_word`, with `tim_we` high for exactly the next cycle. With `switch_en`=0, or in the same cycle as `start`, a select produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a recomputation |
| variant | input | 1 | 0: legacy 30 ns tick, 1: newer 15 ns tick |
| present | input | 2 | Per-drive presence (bit d = drive d) |
| dma_en | input | 2 | Per-drive multiword DMA enable |
| udma_en | input | 2 | Per-drive Ultra DMA enable |
| pio_mode | input | 6 | PIO mode, drive d in bits [3d+2:3d] |
| dma_mode | input | 6 | Multiword DMA mode, drive d in bits [3d+2:3d] |
| udma_mode | input | 6 | Ultra DMA mode, drive d in bits [3d+2:3d] |
| sel_valid | input | 1 | Drive-select pulse |
| sel_drive | input | 1 | Index of the selected drive |
| done | output | 1 | One-cycle completion pulse |
| tim_we | output | 1 | Timing-register write strobe |
| tim_word | output | 32 | Value written to the timing register |
| switch_en | output | 1 | Per-select reprogramming enabled |
| word0 | output | 32 | Latched timing word of drive 0 |
| word1 | output | 32 | Latched timing word of drive 1 |

## Verification
The assertions assume that `start` is a single-cycle pulse that is issued only while the block is idle, and that `sel_valid` is also a pulse. The timing-register properties compare against the words held one cycle earlier, and a start pulse that arrives mid-computation is unused. The stimulus changes every input on the falling clock edge. It holds each start and select pulse for exactly one cycle, and it issues a new start only after the previous `done`. The one exception is a deliberate start-with-select cycle, which is issued from idle.

// File: rtl/ite_pkg.sv
package ite_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] tword_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DECIDE
    } ite_state_t;

    // tick periods in ns for each controller generation
    localparam int LEGACY_TICK_NS = 30;
    localparam int NEWER_TICK_NS  = 15;
    localparam int LEGACY_PIO_OFS = 4;
    localparam int LEGACY_DMA_OFS = 1;
    localparam int LEGACY_MIN     = 1;

    // field positions, legacy layout
    localparam int L_PIO_ACT = 0;
    localparam int L_PIO_REC = 5;
    localparam int L_DMA_ACT = 11;
    localparam int L_DMA_REC = 16;
    // field positions, newer layout
    localparam int N_PIO_ACT = 0;
    localparam int N_PIO_REC = 5;
    localparam int N_DMA_ACT = 10;
    localparam int N_DMA_REC = 15;
    localparam int N_UDMA_EN = 20;
    localparam int N_UDMA_CY = 21;
    localparam int N_UDMA_AC = 25;

    function automatic int pio_cycle_ns(input int m);
        case (m)
            0: return 600;
            1: return 390;
            2: return 240;
            3: return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int pio_active_ns(input int m);
        case (m)
            0: return 180;
            1: return 150;
            2: return 105;
            3: return 90;
            default: return 75;
        endcase
    endfunction

    function automatic int dma_cycle_ns(input int m);
        case (m)
            0: return 480;
            1: return 165;
            default: return 120;
        endcase
    endfunction

    function automatic int dma_active_ns(input int m);
        case (m)
            0: return 240;
            1: return 90;
            default: return 75;
        endcase
    endfunction

    function automatic int udma_cycle_ns(input int m);
        case (m)
            0: return 120;
            1: return 90;
            2: return 60;
            3: return 45;
            default: return 30;
        endcase
    endfunction

    function automatic int udma_active_ns(input int m);
        case (m)
            0: return 180;
            1: return 150;
            2: return 120;
            default: return 90;
        endcase
    endfunction

    // round-up division of a time by the tick period
    function automatic int ns_to_ticks(input int ns, input logic fine);
        int per;
        per = fine ? NEWER_TICK_NS : LEGACY_TICK_NS;
        return (ns + per - 1) / per;
    endfunction

endpackage

// File: rtl/ite_drive_word.sv
module ite_drive_word
    import ite_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              fine,
    input  logic              present,
    input  logic              dma_en,
    input  logic              udma_en,
    input  logic [MODE_W-1:0] pio_mode,
    input  logic [MODE_W-1:0] dma_mode,
    input  logic [MODE_W-1:0] udma_mode,
    output tword_t            word
);

    always_comb begin
        int pc, pa, pr;
        int dc, da, dr;
        int uc, ua;
        tword_t w;

        pc = ns_to_ticks(pio_cycle_ns(int'(pio_mode)), fine);
        pa = ns_to_ticks(pio_active_ns(int'(pio_mode)), fine);
        dc = ns_to_ticks(dma_cycle_ns(int'(dma_mode)), fine);
        da = ns_to_ticks(dma_active_ns(int'(dma_mode)), fine);
        uc = ns_to_ticks(udma_cycle_ns(int'(udma_mode)), fine);
        ua = ns_to_ticks(udma_active_ns(int'(udma_mode)), fine);

        if (fine) begin
            pr = pc - pa;
            dr = dc - da;
        end else begin
            if (pa < LEGACY_MIN) pa = LEGACY_MIN;
            pr = pc - pa - LEGACY_PIO_OFS;
            if (pr < LEGACY_MIN) pr = LEGACY_MIN;
            dr = dc - da - LEGACY_DMA_OFS;
            if (dr < LEGACY_MIN) dr = LEGACY_MIN;
        end

        w = '0;
        if (present) begin
            if (fine) begin
                w = w | (tword_t'(pa) << N_PIO_ACT) | (tword_t'(pr) << N_PIO_REC);
                if (dma_en)
                    w = w | (tword_t'(da) << N_DMA_ACT) | (tword_t'(dr) << N_DMA_REC);
                if (udma_en)
                    w = w | (tword_t'(1) << N_UDMA_EN) | (tword_t'(uc) << N_UDMA_CY)
                          | (tword_t'(ua) << N_UDMA_AC);
            end else begin
                w = w | (tword_t'(pa) << L_PIO_ACT) | (tword_t'(pr) << L_PIO_REC);
                if (dma_en)
                    w = w | (tword_t'(da) << L_DMA_ACT) | (tword_t'(dr) << L_DMA_REC);
            end
        end
        word = w;
    end

endmodule

// File: rtl/ite_ctrl.sv
module ite_ctrl
    import ite_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sel_valid,
    input  logic         sel_drive,
    input  tword_t [1:0] calc_w,
    output logic         capture,
    output logic         done,
    output logic         tim_we,
    output tword_t       tim_word,
    output logic         switch_en,
    output tword_t       w0_q,
    output tword_t       w1_q
);

    ite_state_t state, state_nx;

    assign capture = (state == ST_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CALC;
            ST_CALC:   state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            tim_we    <= 1'b0;
            tim_word  <= '0;
            switch_en <= 1'b0;
            w0_q      <= '0;
            w1_q      <= '0;
        end else begin
            done   <= 1'b0;
            tim_we <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        switch_en <= 1'b0;
                    end else if (sel_valid && switch_en) begin
                        tim_we   <= 1'b1;
                        tim_word <= sel_drive ? w1_q : w0_q;
                    end
                end
                ST_CALC: begin
                    w0_q <= calc_w[0];
                    w1_q <= calc_w[1];
                end
                ST_DECIDE: begin
                    done <= 1'b1;
                    if (w0_q != '0) begin
                        tim_we    <= 1'b1;
                        tim_word  <= w0_q;
                        switch_en <= (w1_q != '0) && (w1_q != w0_q);
                    end else if (w1_q != '0) begin
                        tim_we   <= 1'b1;
                        tim_word <= w1_q;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ide_tim_enc.sv
module ide_tim_enc
    import ite_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int DRIVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     variant,
    input  logic [DRIVES-1:0]        present,
    input  logic [DRIVES-1:0]        dma_en,
    input  logic [DRIVES-1:0]        udma_en,
    input  logic [DRIVES*MODE_W-1:0] pio_mode,
    input  logic [DRIVES*MODE_W-1:0] dma_mode,
    input  logic [DRIVES*MODE_W-1:0] udma_mode,
    input  logic                     sel_valid,
    input  logic                     sel_drive,
    output logic                     done,
    output logic                     tim_we,
    output logic [WORD_W-1:0]        tim_word,
    output logic                     switch_en,
    output logic [WORD_W-1:0]        word0,
    output logic [WORD_W-1:0]        word1
);

    localparam int MW = DRIVES * MODE_W;

    logic                  capture;
    logic                  var_q;
    logic [DRIVES-1:0]     pres_q, dma_q, udma_q;
    logic [MW-1:0]         pio_q, dmam_q, udmam_q;
    tword_t [1:0]          calc_w;

    // inputs are snapshotted on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            var_q   <= 1'b0;
            pres_q  <= '0;
            dma_q   <= '0;
            udma_q  <= '0;
            pio_q   <= '0;
            dmam_q  <= '0;
            udmam_q <= '0;
        end else if (capture) begin
            var_q   <= variant;
            pres_q  <= present;
            dma_q   <= dma_en;
            udma_q  <= udma_en;
            pio_q   <= pio_mode;
            dmam_q  <= dma_mode;
            udmam_q <= udma_mode;
        end
    end

    for (genvar d = 0; d < 2; d++) begin : g_drv
        ite_drive_word #(.MODE_W(MODE_W)) u_word (
            .fine      (var_q),
            .present   (pres_q[d]),
            .dma_en    (dma_q[d]),
            .udma_en   (udma_q[d]),
            .pio_mode  (pio_q[d*MODE_W +: MODE_W]),
            .dma_mode  (dmam_q[d*MODE_W +: MODE_W]),
            .udma_mode (udmam_q[d*MODE_W +: MODE_W]),
            .word      (calc_w[d])
        );
    end

    ite_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sel_valid (sel_valid),
        .sel_drive (sel_drive),
        .calc_w    (calc_w),
        .capture   (capture),
        .done      (done),
        .tim_we    (tim_we),
        .tim_word  (tim_word),
        .switch_en (switch_en),
        .w0_q      (word0),
        .w1_q      (word1)
    );

endmodule

// File: rtl/ide_tim_enc_chk.sv
module ide_tim_enc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        sel_valid,
    input logic        sel_drive,
    input logic        done,
    input logic        tim_we,
    input logic [31:0] tim_word,
    input logic        switch_en,
    input logic [31:0] word0,
    input logic [31:0] word1
);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 3));

    p_write_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tim_we |-> (tim_word != 32'd0));

    p_switch_words_r10: assert property (@(posedge clk) disable iff (!rst_n)
        switch_en |-> (word0 != 32'd0 && word1 != 32'd0 && word0 != word1));

    p_sel_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_we && !done) |-> ($past(sel_valid) && $past(switch_en) &&
            tim_word == ($past(sel_drive) ? $past(word1) : $past(word0))));

    p_sel_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_we && !done) |=> !tim_we);

endmodule

bind ide_tim_enc ide_tim_enc_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sel_valid (sel_valid),
    .sel_drive (sel_drive),
    .done      (done),
    .tim_we    (tim_we),
    .tim_word  (tim_word),
    .switch_en (switch_en),
    .word0     (word0),
    .word1     (word1)
);

// File: tb/ide_tim_enc_tb.sv
module ide_tim_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        variant = 1'b0;
    logic [1:0]  present = '0, dma_en = '0, udma_en = '0;
    logic [5:0]  pio_mode = '0, dma_mode = '0, udma_mode = '0;
    logic        sel_valid = 1'b0, sel_drive = 1'b0;
    logic        done, tim_we, switch_en;
    logic [31:0] tim_word, word0, word1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ide_tim_enc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
        .present(present), .dma_en(dma_en), .udma_en(udma_en),
        .pio_mode(pio_mode), .dma_mode(dma_mode), .udma_mode(udma_mode),
        .sel_valid(sel_valid), .sel_drive(sel_drive),
        .done(done), .tim_we(tim_we), .tim_word(tim_word),
        .switch_en(switch_en), .word0(word0), .word1(word1)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                summary();
            end
        end
    end

    task automatic cfg(input logic v, input logic [1:0] p, input logic [1:0] d,
                       input logic [1:0] u, input logic [2:0] pm0, input logic [2:0] pm1,
                       input logic [2:0] dm0, input logic [2:0] dm1,
                       input logic [2:0] um0, input logic [2:0] um1);
        variant = v; present = p; dma_en = d; udma_en = u;
        pio_mode = {pm1, pm0}; dma_mode = {dm1, dm0}; udma_mode = {um1, um0};
    endtask

    // pulse start, wait for done, check words and the initial write
    task automatic run(input string req, input logic [31:0] e0, input logic [31:0] e1,
                       input logic ewe, input logic [31:0] ewd, input logic esw);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "done latency", 32'(n), 32'd3);
        chk(req, "word0", word0, e0);
        chk(req, "word1", word1, e1);
        chk("R9", "initial tim_we", {31'd0, tim_we}, {31'd0, ewe});
        if (ewe) chk("R9", "initial tim_word", tim_word, ewd);
        chk("R10", "switch_en", {31'd0, switch_en}, {31'd0, esw});
        @(negedge clk);
        chk("R9", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic select(input logic drv, input logic ewe, input logic [31:0] ewd);
        @(negedge clk);
        sel_valid = 1'b1; sel_drive = drv;
        @(negedge clk);
        sel_valid = 1'b0;
        chk("R11", "select tim_we", {31'd0, tim_we}, {31'd0, ewe});
        if (ewe) chk("R11", "select tim_word", tim_word, ewd);
        @(negedge clk);
        chk("R11", "strobe one cycle", {31'd0, tim_we}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "tim_we", {31'd0, tim_we}, 32'd0);
        chk("R1", "tim_word", tim_word, 32'd0);
        chk("R1", "switch_en", {31'd0, switch_en}, 32'd0);
        chk("R1", "word0", word0, 32'd0);
        chk("R1", "word1", word1, 32'd0);
    endtask

    task automatic t_legacy_pio();
        // R2 R3: pio0 -> 20/6 ticks, rec 10; pio4 -> 4/3, rec clamps to 1
        cfg(1'b0, 2'b11, 2'b00, 2'b00, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0);
        run("R3", 32'h146, 32'h23, 1'b1, 32'h146, 1'b1);
        select(1'b1, 1'b1, 32'h23);
        select(1'b0, 1'b1, 32'h146);
    endtask

    task automatic t_legacy_dma();
        // R4: dma0 -> act 8 rec 7; dma1 -> act 3 rec 2; udma enable ignored
        cfg(1'b0, 2'b11, 2'b11, 2'b10, 3'd1, 3'd2, 3'd0, 3'd1, 3'd0, 3'd4);
        run("R4", 32'h74085, 32'h21824, 1'b1, 32'h74085, 1'b1);
        // R4 R10: dma2 rec clamps to 1; identical words -> no switching
        cfg(1'b0, 2'b11, 2'b11, 2'b00, 3'd3, 3'd3, 3'd2, 3'd2, 3'd0, 3'd0);
        run("R4", 32'h11823, 32'h11823, 1'b1, 32'h11823, 1'b0);
        select(1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_newer();
        // R5 R6: no offset, 15 ns ticks
        cfg(1'b1, 2'b11, 2'b11, 2'b10, 3'd0, 3'd4, 3'd0, 3'd2, 3'd0, 3'd4);
        run("R5", 32'h8438C, 32'h0C519465, 1'b1, 32'h8438C, 1'b1);
        // R6 R7: udma0 on drive 0; absent drive 1 with enables set gets zero
        cfg(1'b1, 2'b01, 2'b10, 2'b11, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
        run("R6", 32'h19100127, 32'h0, 1'b1, 32'h19100127, 1'b0);
    endtask

    task automatic t_absent();
        // R7 R9: only drive 1 nonzero -> its word written, no switching
        cfg(1'b0, 2'b10, 2'b01, 2'b00, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
        run("R7", 32'h0, 32'h146, 1'b1, 32'h146, 1'b0);
        // R9: both absent -> no write at all
        cfg(1'b0, 2'b00, 2'b11, 2'b11, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
        run("R7", 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_saturate();
        // R8: pio 7 acts as 4, dma 3 acts as 2
        cfg(1'b0, 2'b11, 2'b01, 2'b00, 3'd7, 3'd0, 3'd3, 3'd0, 3'd0, 3'd0);
        run("R8", 32'h11823, 32'h146, 1'b1, 32'h11823, 1'b1);
        // R8: newer pio 5 acts as 4, udma 6 acts as 4
        cfg(1'b1, 2'b01, 2'b00, 2'b01, 3'd5, 3'd0, 3'd0, 3'd0, 3'd6, 3'd0);
        run("R8", 32'h0C500065, 32'h0, 1'b1, 32'h0C500065, 1'b0);
    endtask

    task automatic t_select_with_start();
        // R11: switching enabled, then select in the same cycle as start
        cfg(1'b0, 2'b11, 2'b00, 2'b00, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0);
        run("R10", 32'h146, 32'h23, 1'b1, 32'h146, 1'b1);
        @(negedge clk);
        start = 1'b1; sel_valid = 1'b1; sel_drive = 1'b1;
        @(negedge clk);
        start = 1'b0; sel_valid = 1'b0;
        chk("R11", "select with start", {31'd0, tim_we}, 32'd0);
        chk("R10", "switch_en cleared during compute", {31'd0, switch_en}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_legacy_pio();
        t_legacy_dma();
        t_newer();
        t_absent();
        t_saturate();
        t_select_with_start();
        summary();
    end

endmodule